// File: doc/BRIEF.md
# NAND Sector Parity Accumulator

This block builds a single-error-correcting parity code for a NAND sector while the sector's bytes cross an 8-bit data bus. Every byte strobe carries a data byte and a chip-select index. When the context for that chip select is armed, the byte is folded into the context's running parity. Each context keeps two 12-bit fields. The upper field is the XOR of the positions of all 1 bits, where a position is the byte offset joined to the bit index. The lower field is the XOR of the complements of those same positions. A single flipped data bit therefore changes the two fields by a position and its exact complement, which is what lets a reader locate the bit.

Software reaches the block through a small register bus. Address 0 is a shared control word. Writing a 1 to bit 8+n arms context n and clears it. Address 1+n returns context n's result, and reading it clears the context. There are four contexts by default. Once a context has taken a full sector of 512 bytes, it holds its result until it is armed again.

Top module: `nand_ecc_acc`

## Requirements
- R1: After reset, every context is disarmed with zero parity, and reads of the control word and of every result return 0.
- R2: A control write (address 0) with bit 8+n set arms context n and zeroes its parity and byte count. A 0 in bit 8+n leaves context n as it was. A control read returns bit 8+n = 1 while context n is armed and still short of a full sector, and 0 in every other bit.
- R3: For each 1 bit of an accepted byte at offset k (0-based within the sector) and bit index i, the upper field XORs in the 12-bit value {k[8:0], i[2:0]}, and the lower field XORs in its bitwise complement.
- R4: A byte strobe changes only the context named by byte_cs, and only when that context is armed. Bytes to a disarmed context are ignored.
- R5: After 512 accepted bytes a context accepts no further bytes until it is armed again, and its control bit reads 0.
- R6: A read of address 1+n returns the lower field in bits 11:0 and the upper field in bits 27:16, with all other bits 0. Read data appears on the cycle after the read strobe and is 0 on every cycle that follows no read.
- R7: Reading a context's result clears its parity and count and disarms it.
- R8: A control write that arms a context wins over a byte strobe to that context in the same cycle, and the byte is dropped. A result read of a context wins over a byte strobe to it in the same cycle, the byte is dropped, and the read returns the value from before that cycle. A write and a read in the same cycle perform the write only.
- R9: For two sectors that differ in one bit at offset k, index i, the XOR of their two results is {k,i} in bits 27:16 and its complement in bits 11:0.
- R10: A sector of 512 bytes of 0xFF yields zero in both fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address: 0 control, 1+n result of context n |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data, valid the cycle after reg_rd |
| byte_stb | input | 1 | One data byte is crossing the bus this cycle |
| byte_cs | input | 2 | Chip-select index of the byte |
| byte_data | input | 8 | Data byte |

## Verification
A byte accepted at one rising edge is already in the parity after that edge. A control write takes effect at the edge that samples it. Read data is registered, so it is valid one edge after the read strobe. The bench drives every strobe for exactly one cycle on a falling edge and samples reg_rdata on the next falling edge, half a cycle after the edge that loads it. A result is read only after the last byte of a sector has been sent and the strobe has dropped. The same-cycle ordering cases put the two strobes on one falling edge, so both are sampled by the same rising edge.

// File: rtl/nand_ecc_acc.sv
module nand_ecc_acc #(
  parameter int NUM_CS       = 4,
  parameter int SECTOR_BYTES = 512,
  parameter int ADDR_W       = 3,
  parameter int START_LSB    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 byte_stb,
  input  logic [((NUM_CS>1)?$clog2(NUM_CS):1)-1:0] byte_cs,
  input  logic [7:0]           byte_data
);
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam int OFF_W = $clog2(SECTOR_BYTES);
  localparam int POS_W = OFF_W + 3;
  localparam int CNT_W = OFF_W + 1;

  logic [NUM_CS-1:0]             armed_q, active, arm, clr, hit;
  logic [NUM_CS-1:0][CNT_W-1:0]  cnt_q;
  logic [NUM_CS-1:0][POS_W-1:0]  up_q, lo_q;
  logic [2:0]                    bit_sum;
  logic                          ones_odd, rd_ok;
  logic [31:0]                   rd_val;

  always_comb begin
    bit_sum = '0;
    for (int i = 0; i < 8; i++)
      if (byte_data[i]) bit_sum = bit_sum ^ 3'(i);
  end

  assign ones_odd = ^byte_data;
  assign rd_ok    = reg_rd & ~reg_wr;

  for (genvar n = 0; n < NUM_CS; n++) begin : g_ctx
    logic [POS_W-1:0] up_inc;

    assign active[n] = armed_q[n] && (cnt_q[n] != CNT_W'(SECTOR_BYTES));
    assign arm[n]    = reg_wr && (reg_addr == '0) && reg_wdata[START_LSB+n];
    assign clr[n]    = rd_ok && (reg_addr == ADDR_W'(n + 1));
    assign hit[n]    = byte_stb && active[n] && (byte_cs == CS_W'(n));
    assign up_inc    = {ones_odd ? cnt_q[n][OFF_W-1:0] : {OFF_W{1'b0}}, bit_sum};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        armed_q[n] <= 1'b0;
        cnt_q[n]   <= '0;
        up_q[n]    <= '0;
        lo_q[n]    <= '0;
      end else if (arm[n]) begin
        armed_q[n] <= 1'b1;
        cnt_q[n]   <= '0;
        up_q[n]    <= '0;
        lo_q[n]    <= '0;
      end else if (clr[n]) begin
        armed_q[n] <= 1'b0;
        cnt_q[n]   <= '0;
        up_q[n]    <= '0;
        lo_q[n]    <= '0;
      end else if (hit[n]) begin
        cnt_q[n] <= cnt_q[n] + 1'b1;
        up_q[n]  <= up_q[n] ^ up_inc;
        lo_q[n]  <= lo_q[n] ^ up_inc ^ {POS_W{ones_odd}};
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (reg_addr == '0) rd_val[START_LSB +: NUM_CS] = active;
    for (int n = 0; n < NUM_CS; n++) begin
      if (reg_addr == ADDR_W'(n + 1)) begin
        rd_val[POS_W-1:0]  = lo_q[n];
        rd_val[16 +: POS_W] = up_q[n];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     reg_rdata <= '0;
    else if (rd_ok) reg_rdata <= rd_val;
    else            reg_rdata <= '0;
  end
endmodule

module nand_ecc_acc_chk #(
  parameter int NUM_CS       = 4,
  parameter int SECTOR_BYTES = 512,
  parameter int ADDR_W       = 3,
  parameter int START_LSB    = 8,
  parameter int CS_W         = 2,
  parameter int CNT_W        = 10,
  parameter int POS_W        = 12
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          reg_wr,
  input logic                          reg_rd,
  input logic [ADDR_W-1:0]             reg_addr,
  input logic [31:0]                   reg_wdata,
  input logic [31:0]                   reg_rdata,
  input logic                          byte_stb,
  input logic [CS_W-1:0]               byte_cs,
  input logic [7:0]                    byte_data,
  input logic [NUM_CS-1:0]             armed_q,
  input logic [NUM_CS-1:0][CNT_W-1:0]  cnt_q,
  input logic [NUM_CS-1:0][POS_W-1:0]  up_q,
  input logic [NUM_CS-1:0][POS_W-1:0]  lo_q
);
  assert_rdata_pad_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[31:16+POS_W] == '0) && (reg_rdata[15:POS_W] == '0));

  assert_rdata_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && !reg_wr) |=> (reg_rdata == '0));

  for (genvar n = 0; n < NUM_CS; n++) begin : g_chk
    assert_arm_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == '0 && reg_wdata[START_LSB+n])
      |=> (armed_q[n] && cnt_q[n] == '0 && up_q[n] == '0 && lo_q[n] == '0));

    assert_no_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[n] <= CNT_W'(SECTOR_BYTES));

    assert_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!(byte_stb && byte_cs == CS_W'(n)) && !reg_wr && !reg_rd)
      |=> ($stable(cnt_q[n]) && $stable(up_q[n]) && $stable(lo_q[n])));

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && !reg_wr && reg_addr == ADDR_W'(n + 1))
      |=> (!armed_q[n] && cnt_q[n] == '0 && up_q[n] == '0 && lo_q[n] == '0));

    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_stb && byte_cs == CS_W'(n) && armed_q[n] && cnt_q[n] < CNT_W'(SECTOR_BYTES)
       && !reg_wr && !reg_rd)
      |=> ((cnt_q[n] == $past(cnt_q[n]) + 1'b1) &&
           (((up_q[n] ^ lo_q[n]) ^ ($past(up_q[n]) ^ $past(lo_q[n])))
             == {POS_W{$past(^byte_data)}})));
  end
endmodule

bind nand_ecc_acc nand_ecc_acc_chk #(
  .NUM_CS(NUM_CS), .SECTOR_BYTES(SECTOR_BYTES), .ADDR_W(ADDR_W),
  .START_LSB(START_LSB), .CS_W(CS_W), .CNT_W(CNT_W), .POS_W(POS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .byte_stb(byte_stb), .byte_cs(byte_cs), .byte_data(byte_data),
  .armed_q(armed_q), .cnt_q(cnt_q), .up_q(up_q), .lo_q(lo_q)
);

// File: tb/nand_ecc_acc_tb.sv
module nand_ecc_acc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  localparam logic [17:0] VEC [NVEC] = '{
    {2'd0, 16'h1234}, {2'd1, 16'hBEEF}, {2'd2, 16'h0001},
    {2'd3, 16'h7A5C}, {2'd0, 16'hFFFF}, {2'd2, 16'h9E37}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        byte_stb = 1'b0;
  logic [1:0]  byte_cs = '0;
  logic [7:0]  byte_data = '0;

  int checks = 0, failures = 0;
  logic [7:0]  sec [512];
  logic [31:0] got, exp_w, a_w;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_ecc_acc u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .byte_stb(byte_stb), .byte_cs(byte_cs), .byte_data(byte_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fill(input logic [15:0] seed);
    logic [31:0] x = {16'h5A5A, seed};
    for (int b = 0; b < 512; b++) begin
      x = x * 32'd1103515245 + 32'd12345;
      sec[b] = x[23:16];
    end
  endtask

  task automatic model(input int n, output logic [31:0] w);
    logic [11:0] up = '0, lo = '0, pos;
    for (int b = 0; b < n; b++)
      for (int i = 0; i < 8; i++)
        if (sec[b][i]) begin
          pos = {b[8:0], i[2:0]};
          up = up ^ pos;
          lo = lo ^ ~pos;
        end
    w = {4'h0, up, 4'h0, lo};
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic send(input logic [1:0] cs, input int first, input int n);
    for (int b = first; b < first + n; b++) begin
      @(negedge clk); byte_stb = 1'b1; byte_cs = cs; byte_data = sec[b];
    end
    @(negedge clk); byte_stb = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, got); check("R1 control after reset", got, 32'h0);
    for (int n = 0; n < 4; n++) begin
      rd(3'(n + 1), got); check("R1 result after reset", got, 32'h0);
    end

    // R3 R6 vector walk of random sectors across contexts
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] cs = VEC[v][17:16];
      fill(VEC[v][15:0]);
      wr(3'd0, 32'h1 << (8 + cs));
      rd(3'd0, got); check("R2 armed bit", got, 32'h1 << (8 + cs));
      send(cs, 0, 512);
      rd(3'd0, got); check("R5 full sector deactivates", got, 32'h0);
      model(512, exp_w);
      rd(3'(cs + 1), got); check("R3 R6 sector parity", got, exp_w);
      rd(3'(cs + 1), got); check("R7 read clears", got, 32'h0);
    end

    // R10 erased sector
    for (int b = 0; b < 512; b++) sec[b] = 8'hFF;
    wr(3'd0, 32'h0000_0200);
    send(2'd1, 0, 512);
    rd(3'd2, got); check("R10 all-ones sector", got, 32'h0);

    // R9 single bit flips at first and last position
    for (int t = 0; t < 2; t++) begin
      int k = (t == 0) ? 0 : 511;
      int i = (t == 0) ? 0 : 7;
      fill(16'hC0DE + 16'(t));
      wr(3'd0, 32'h0000_0800);
      send(2'd3, 0, 512);
      rd(3'd4, a_w);
      sec[k][i] = ~sec[k][i];
      wr(3'd0, 32'h0000_0800);
      send(2'd3, 0, 512);
      rd(3'd4, got);
      exp_w = {4'h0, k[8:0], i[2:0], 4'h0, ~{k[8:0], i[2:0]}};
      check("R9 flip syndrome", got ^ a_w, exp_w);
    end

    // R4 bytes to a disarmed context are ignored; only the named context moves
    fill(16'h4444);
    wr(3'd0, 32'h0000_0100);
    send(2'd1, 0, 40);
    send(2'd0, 0, 512);
    model(512, exp_w);
    rd(3'd1, got); check("R4 armed context unaffected by other cs", got, exp_w);
    rd(3'd2, got); check("R4 disarmed context stays zero", got, 32'h0);

    // R2 writing zero does not disarm; R5 extra bytes ignored
    fill(16'h5151);
    wr(3'd0, 32'h0000_0200);
    wr(3'd0, 32'h0000_0000);
    rd(3'd0, got); check("R2 zero write keeps armed", got, 32'h0000_0200);
    send(2'd1, 0, 512);
    send(2'd1, 0, 7);
    model(512, exp_w);
    rd(3'd2, got); check("R5 bytes past sector ignored", got, exp_w);

    // R8 arm wins over same-cycle byte
    fill(16'h8888);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h0000_0400;
    byte_stb = 1'b1; byte_cs = 2'd2; byte_data = 8'hA5;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; byte_stb = 1'b0;
    send(2'd2, 0, 512);
    model(512, exp_w);
    rd(3'd3, got); check("R8 arm drops same-cycle byte", got, exp_w);

    // R8 read wins over same-cycle byte
    wr(3'd0, 32'h0000_0400);
    send(2'd2, 0, 10);
    model(10, exp_w);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 3'd3;
    byte_stb = 1'b1; byte_cs = 2'd2; byte_data = 8'hFF;
    @(negedge clk);
    reg_rd = 1'b0; byte_stb = 1'b0; got = reg_rdata;
    check("R8 read returns pre-cycle value", got, exp_w);
    rd(3'd3, got); check("R8 byte dropped on read", got, 32'h0);

    // R8 write and read together: only the write happens
    wr(3'd0, 32'h0000_0100);
    send(2'd0, 0, 3);
    @(negedge clk);
    reg_wr = 1'b1; reg_rd = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h0;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0; got = reg_rdata;
    check("R8 simultaneous write suppresses read data", got, 32'h0);
    model(3, exp_w);
    rd(3'd1, got); check("R8 context intact after write+read", got, exp_w);

    // R1 reset in mid-sector
    wr(3'd0, 32'h0000_0F00);
    send(2'd1, 0, 20);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(3'd0, got); check("R1 control after mid-run reset", got, 32'h0);
    rd(3'd2, got); check("R1 result after mid-run reset", got, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule